// File: doc/BRIEF.md
# Debug trigger state sequencer

This block is the state machine that turns comparator match pulses into a debug trigger. It walks from an entry state through two intermediate states to a final state. Four comparator channels feed it single-cycle match pulses, and a per-channel enable decides which pulses count. Each non-final state has its own 4-bit rule selector. The rule in force for the current state decides which channels move the sequencer and where they send it. Channels that the rule does not name are ignored.

The selectors sit behind a small register port. There is one fixed offset, and a 2-bit bank field picks which state's selector is seen there. The selectors can be read at any time. They can be changed only while the sequencer is disarmed. Raising `arm` starts the sequence from the entry state. Dropping `arm` returns the sequencer to the entry state. Once the final state is reached, the sequencer stays there and flags it until it is disarmed.

Top module: `seqr_top`

## Requirements
- R1: After reset, `seqState` is 00 (entry state), `finalFlag` is 0 and every selector reads as zero.
- R2: At `regAddr` 0x27, bank 00, 01 and 10 read the selector of the entry state, the second state and the third state, in bits 3:0. Bits 7:4 always read 0. Any other address, or bank 11, reads 0x00, and writes to it change no selector.
- R3: A write while `arm` is high leaves every selector unchanged.
- R4: Codes 0, 1 and 2 send any enabled match to state 01, 10 or 11 respectively.
- R5: Codes 3, 4 and 5 react only to channel 2, sending it to state 01, 10 or 11 respectively.
- R6: The two-channel codes route as follows:
  - 6: ch0 to 01, ch1 to 10.
  - 7: ch1 to 10, ch0 to 11.
  - 8: ch0 to 01, ch2 to 10.
  - 9: ch2 to 10, ch0 to 11.
  - 10: ch1 to 01, ch3 to 10.
  - 11: ch3 to 10, ch1 to 11.
  Channels a code does not name have no effect.
- R7: Codes 12 to 15 never cause a transition.
- R8: A match pulse on a channel whose `matchEn` bit is 0 has no effect.
- R9: When matches in one cycle name different targets, state 11 wins over 10, and 10 wins over 01.
- R10: While `arm` is low, the state becomes 00 at the next clock edge.
- R11: State 11 is held while `arm` stays high. `finalFlag` is 1 exactly when `seqState` is 11.
- R12: A match sampled at a clock edge moves the state at that edge, using only the rule of the state held before the edge. At most one transition is taken per edge. State encoding: 00 entry, 01 second, 10 third, 11 final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Enables sequencing; low forces the entry state and unlocks writes |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register offset |
| regBank | input | 2 | Bank select; picks which state's selector is seen |
| regWdata | input | 8 | Write data; bits 3:0 are stored |
| regRdata | output | 8 | Read data for the addressed register |
| matchIn | input | 4 | Single-cycle comparator match pulses |
| matchEn | input | 4 | Per-channel comparator enable |
| seqState | output | 2 | Current sequencer state |
| finalFlag | output | 1 | High while in the final state |

## Verification
The hardest case to reach is a rule belonging to the second or third state. A selector written through banks 01 or 10 only matters after earlier matches have moved the sequencer there under the entry rule. The stimulus programs all three selectors while disarmed and then arms. It walks through the states with chosen channels, including a cycle where the pattern would jump two states if rules were chained. It also sweeps every code and every match pattern on the entry rule, with full and partial enables, and then runs a long random phase. A reference model in the bench predicts each cycle's result.

// File: rtl/seqr_pkg.sv
`timescale 1ns/1ps
package seqr_pkg;
  localparam int NUM_CH = 4;
  localparam int SEL_W = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int BANK_W = 2;
  localparam int NUM_RULE_ST = 3;
  localparam logic [ADDR_W-1:0] SEL_OFFSET = 8'h27;

  typedef enum logic [1:0] {
    ST_ONE   = 2'd0,
    ST_TWO   = 2'd1,
    ST_THREE = 2'd2,
    ST_FINAL = 2'd3
  } seqState_e;

  typedef struct packed {
    logic              load;
    logic [BANK_W-1:0] bank;
  } regStrobe_t;
endpackage

// File: rtl/seqr_rule.sv
`timescale 1ns/1ps
module seqr_rule
  import seqr_pkg::*;
#(
  parameter int CH = NUM_CH,
  parameter int SW = SEL_W
) (
  input  logic [SW-1:0] rule,
  input  logic [CH-1:0] matchIn,
  input  logic [CH-1:0] matchEn,
  output logic          hitValid,
  output seqState_e     hitTarget
);
  logic [CH-1:0] eff;
  logic toTwo, toThree, toFinal;
  logic anyHit;

  assign eff = matchIn & matchEn;
  assign anyHit = |eff;

  always_comb begin
    toTwo = 1'b0;
    toThree = 1'b0;
    toFinal = 1'b0;
    case (rule)
      4'd0: toTwo = anyHit;
      4'd1: toThree = anyHit;
      4'd2: toFinal = anyHit;
      4'd3: toTwo = eff[2];
      4'd4: toThree = eff[2];
      4'd5: toFinal = eff[2];
      4'd6: begin toTwo = eff[0]; toThree = eff[1]; end
      4'd7: begin toThree = eff[1]; toFinal = eff[0]; end
      4'd8: begin toTwo = eff[0]; toThree = eff[2]; end
      4'd9: begin toThree = eff[2]; toFinal = eff[0]; end
      4'd10: begin toTwo = eff[1]; toThree = eff[3]; end
      4'd11: begin toThree = eff[3]; toFinal = eff[1]; end
      default: ;
    endcase
  end

  // final beats third, third beats second
  always_comb begin
    hitValid = toFinal | toThree | toTwo;
    if (toFinal) hitTarget = ST_FINAL;
    else if (toThree) hitTarget = ST_THREE;
    else hitTarget = ST_TWO;
  end
endmodule

// File: rtl/seqr_regs.sv
`timescale 1ns/1ps
module seqr_regs
  import seqr_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int BW = BANK_W,
  parameter int NR = NUM_RULE_ST
) (
  input  logic            clk,
  input  logic            rstN,
  input  regStrobe_t      strobe,
  input  logic [DW-1:0]   wdata,
  input  logic [AW-1:0]   regAddr,
  input  logic [BW-1:0]   regBank,
  input  seqState_e       curState,
  output logic [DW-1:0]   rdData,
  output logic [SW-1:0]   curRule,
  output logic [NR*SW-1:0] selFlat
);
  logic [SW-1:0] sel [NR];

  for (genvar g = 0; g < NR; g++) begin : gSel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sel[g] <= '0;
      else if (strobe.load && strobe.bank == BW'(g)) sel[g] <= wdata[SW-1:0];
    end
    assign selFlat[g*SW +: SW] = sel[g];
  end

  always_comb begin
    rdData = '0;
    curRule = '0;
    for (int i = 0; i < NR; i++) begin
      if (regAddr == SEL_OFFSET && regBank == BW'(i))
        rdData = {{(DW-SW){1'b0}}, sel[i]};
      if (curState == seqState_e'(i))
        curRule = sel[i];
    end
  end
endmodule

// File: rtl/seqr_ctrl.sv
`timescale 1ns/1ps
module seqr_ctrl
  import seqr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BANK_W,
  parameter int NR = NUM_RULE_ST
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          arm,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [BW-1:0] regBank,
  input  logic          hitValid,
  input  seqState_e     hitTarget,
  output regStrobe_t    strobe,
  output seqState_e     curState
);
  always_comb begin
    strobe.load = regWrEn && !arm && regAddr == SEL_OFFSET && 32'(regBank) < NR;
    strobe.bank = regBank;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_ONE;
    else if (!arm) curState <= ST_ONE;
    else if (curState != ST_FINAL && hitValid) curState <= hitTarget;
  end
endmodule

// File: rtl/seqr_top.sv
`timescale 1ns/1ps
module seqr_top
  import seqr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              arm,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BANK_W-1:0] regBank,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [NUM_CH-1:0] matchIn,
  input  logic [NUM_CH-1:0] matchEn,
  output logic [1:0]        seqState,
  output logic              finalFlag
);
  regStrobe_t strobe;
  seqState_e curState, hitTarget;
  logic hitValid;
  logic [SEL_W-1:0] curRule;
  logic [NUM_RULE_ST*SEL_W-1:0] selFlat;

  seqr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .regWrEn(regWrEn),
    .regAddr(regAddr), .regBank(regBank),
    .hitValid(hitValid), .hitTarget(hitTarget),
    .strobe(strobe), .curState(curState)
  );

  seqr_regs i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata),
    .regAddr(regAddr), .regBank(regBank), .curState(curState),
    .rdData(regRdata), .curRule(curRule), .selFlat(selFlat)
  );

  seqr_rule i_rule (
    .rule(curRule), .matchIn(matchIn), .matchEn(matchEn),
    .hitValid(hitValid), .hitTarget(hitTarget)
  );

  assign seqState = curState;
  assign finalFlag = (curState == ST_FINAL);
endmodule

// File: rtl/seqr_checker.sv
`timescale 1ns/1ps
module seqr_checker
  import seqr_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         arm,
  input logic [1:0]                   seqState,
  input logic [DATA_W-1:0]            regRdata,
  input logic [NUM_CH-1:0]            matchIn,
  input logic [NUM_CH-1:0]            matchEn,
  input logic [SEL_W-1:0]             curRule,
  input logic [NUM_RULE_ST*SEL_W-1:0] selFlat
);
  assert_disarm_R10: assert property (@(posedge clk) disable iff (!rstN)
    !arm |=> seqState == 2'd0);

  assert_final_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (arm && seqState == 2'd3) |=> seqState == 2'd3);

  assert_wr_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> $stable(selFlat));

  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rstN)
    (arm && curRule >= 4'd12) |=> $stable(seqState));

  assert_en_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (arm && (matchIn & matchEn) == '0) |=> $stable(seqState));

  assert_rd_upper_R2: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:SEL_W] == '0);
endmodule

bind seqr_top seqr_checker i_chk (
  .clk(clk), .rstN(rstN), .arm(arm), .seqState(seqState),
  .regRdata(regRdata), .matchIn(matchIn), .matchEn(matchEn),
  .curRule(curRule), .selFlat(selFlat)
);

// File: tb/test_seqr_top.sv
`timescale 1ns/1ps
module test_seqr_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arm = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [1:0] regBank = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [3:0] matchIn = '0;
  logic [3:0] matchEn = '0;
  logic [1:0] seqState;
  logic finalFlag;

  int nChecks = 0;
  int nFails = 0;

  typedef struct {
    logic [1:0] st;
    logic       fin;
    logic [7:0] rd;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [3:0] mSel [3];
  logic [1:0] mSt;

  seqr_top i_seqr_top (
    .clk(clk), .rstN(rstN), .arm(arm), .regWrEn(regWrEn),
    .regAddr(regAddr), .regBank(regBank), .regWdata(regWdata),
    .regRdata(regRdata), .matchIn(matchIn), .matchEn(matchEn),
    .seqState(seqState), .finalFlag(finalFlag)
  );

  always #4 clk = ~clk;

  // target per channel: 0 none, 1/2/3 = state 01/10/11 (numeric max = priority)
  function automatic int chTarget(input logic [3:0] code, input int ch);
    case (code)
      4'd0: return 1;
      4'd1: return 2;
      4'd2: return 3;
      4'd3: return (ch == 2) ? 1 : 0;
      4'd4: return (ch == 2) ? 2 : 0;
      4'd5: return (ch == 2) ? 3 : 0;
      4'd6: return (ch == 0) ? 1 : (ch == 1) ? 2 : 0;
      4'd7: return (ch == 1) ? 2 : (ch == 0) ? 3 : 0;
      4'd8: return (ch == 0) ? 1 : (ch == 2) ? 2 : 0;
      4'd9: return (ch == 2) ? 2 : (ch == 0) ? 3 : 0;
      4'd10: return (ch == 1) ? 1 : (ch == 3) ? 2 : 0;
      4'd11: return (ch == 3) ? 2 : (ch == 1) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] modelRead(input logic [7:0] ad, input logic [1:0] bk);
    if (ad == 8'h27 && bk != 2'd3) return {4'h0, mSel[bk]};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic [3:0] m, input logic [3:0] e,
                      input logic w, input logic [7:0] ad, input logic [1:0] bk,
                      input logic [7:0] wd, input string tag);
    expItem_t it;
    int best;
    @(negedge clk);
    arm = a; matchIn = m; matchEn = e; regWrEn = w;
    regAddr = ad; regBank = bk; regWdata = wd;
    best = 0;
    if (mSt != 2'd3 && mSt != 2'd0 || mSt == 2'd0) begin
      if (mSt != 2'd3)
        for (int c = 0; c < 4; c++)
          if (m[c] && e[c] && chTarget(mSel[mSt], c) > best) best = chTarget(mSel[mSt], c);
    end
    if (w && !a && ad == 8'h27 && bk != 2'd3) mSel[bk] = wd[3:0];
    if (!a) mSt = 2'd0;
    else if (best != 0) mSt = 2'(best);
    it.st = mSt;
    it.fin = (mSt == 2'd3);
    it.rd = modelRead(ad, bk);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: results visible 1ns after the edge that consumed the inputs
  always @(posedge clk) begin
    #1;
    if (rstN && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check({it.tag, " state"}, 32'(seqState), 32'(it.st));
      check({it.tag, " flag R11"}, 32'(finalFlag), 32'(it.fin));
      check({it.tag, " rdata"}, 32'(regRdata), 32'(it.rd));
    end
  end

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL R12 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  function automatic string codeTag(input logic [3:0] code, input logic [3:0] p, input logic [3:0] e);
    if ($countones(p & e) > 1) return "R9";
    if (e != 4'hF) return "R8";
    if (code < 3) return "R4";
    if (code < 6) return "R5";
    if (code < 12) return "R6";
    return "R7";
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) mSel[i] = 4'h0;
    mSt = 2'd0;
    // R1: reset state
    #20;
    check("R1 state", 32'(seqState), 32'd0);
    check("R1 flag", 32'(finalFlag), 32'd0);
    regAddr = 8'h27;
    for (int b = 0; b < 3; b++) begin
      regBank = 2'(b);
      #1;
      check("R1 selector", 32'(regRdata), 32'd0);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R2: register access, upper bits, banks, wrong address
    step(0, 4'h0, 4'hF, 1, 8'h27, 2'd0, 8'hA6, "R2");
    step(0, 4'h0, 4'hF, 1, 8'h27, 2'd1, 8'h5B, "R2");
    step(0, 4'h0, 4'hF, 1, 8'h27, 2'd2, 8'hFC, "R2");
    step(0, 4'h0, 4'hF, 1, 8'h27, 2'd3, 8'h09, "R2");
    step(0, 4'h0, 4'hF, 1, 8'h26, 2'd0, 8'h01, "R2");
    step(0, 4'h0, 4'hF, 0, 8'h27, 2'd0, 8'h00, "R2");
    step(0, 4'h0, 4'hF, 0, 8'h27, 2'd1, 8'h00, "R2");
    step(0, 4'h0, 4'hF, 0, 8'h27, 2'd2, 8'h00, "R2");
    step(0, 4'h0, 4'hF, 0, 8'h27, 2'd3, 8'h00, "R2");

    // R3: writes while armed are dropped
    step(1, 4'h0, 4'h0, 1, 8'h27, 2'd0, 8'h03, "R3");
    step(1, 4'h0, 4'h0, 1, 8'h27, 2'd2, 8'h01, "R3");
    step(1, 4'h0, 4'h0, 0, 8'h27, 2'd0, 8'h00, "R3");
    step(1, 4'h0, 4'h0, 0, 8'h27, 2'd2, 8'h00, "R3");

    // R4-R9: sweep every entry-state code against every pattern
    for (int code = 0; code < 16; code++) begin
      for (int p = 1; p < 16; p++) begin
        for (int ev = 0; ev < 2; ev++) begin
          logic [3:0] en;
          en = (ev == 0) ? 4'hF : 4'(p ^ (code & 4'h5));
          step(0, 4'h0, en, 1, 8'h27, 2'd0, 8'(code), "R10");
          step(1, 4'h0, en, 0, 8'h27, 2'd0, 8'h00, "R12");
          step(1, 4'(p), en, 0, 8'h27, 2'd0, 8'h00, codeTag(4'(code), 4'(p), en));
          step(1, 4'h0, en, 0, 8'h27, 2'd0, 8'h00, "R12");
        end
      end
    end

    // R12: later-state rules and no chaining within one edge
    step(0, 4'h0, 4'hF, 1, 8'h27, 2'd0, 8'h00, "R2");
    step(0, 4'h0, 4'hF, 1, 8'h27, 2'd1, 8'h04, "R2");
    step(0, 4'h0, 4'hF, 1, 8'h27, 2'd2, 8'h02, "R2");
    step(1, 4'h4, 4'hF, 0, 8'h27, 2'd1, 8'h00, "R12");
    step(1, 4'h1, 4'hF, 0, 8'h27, 2'd1, 8'h00, "R12");
    step(1, 4'h4, 4'hF, 0, 8'h27, 2'd2, 8'h00, "R12");
    step(1, 4'h2, 4'hF, 0, 8'h27, 2'd2, 8'h00, "R12");
    step(1, 4'hF, 4'hF, 0, 8'h27, 2'd0, 8'h00, "R11");
    step(1, 4'h0, 4'hF, 1, 8'h27, 2'd0, 8'h0B, "R3");
    step(1, 4'h5, 4'hF, 0, 8'h27, 2'd0, 8'h00, "R11");
    step(0, 4'hF, 4'hF, 0, 8'h27, 2'd0, 8'h00, "R10");
    step(0, 4'hF, 4'hF, 0, 8'h27, 2'd0, 8'h00, "R10");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[3:0] != 4'h0), r[7:4] & r[11:8], r[15:12] | r[19:16], r[20],
           r[21] ? 8'h27 : 8'h28, r[23:22], r[31:24], "R12");
    end

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule